// File: doc/BRIEF.md
# Dual-Mode Bus Recovery Controller

This block chooses whether a small serial memory behaves as a free-running streamer, clocked by a slow streaming clock, or as a command-driven two-wire slave. After power-up it streams. A falling edge on the two-wire bus clock while the data line is released moves it into a transitional state. In that state a watchdog counts rising edges of the streaming clock. If no valid command is acknowledged before the count reaches its limit, the block falls back to streaming and restarts the streamer at address zero.

When the slave engine acknowledges an address whose upper four bits match the device code, the block locks into command mode. Only reset, which stands for a power cycle, releases the lock. A stop condition seen during the address phase, before any acknowledge, also sends the block back to streaming. All bus and streaming-clock inputs are sampled by the system clock `clk`, and edges are detected between successive samples. The mode output and the restart pulse are both registered.

Top module: `bus_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 2'b00 (streaming) and `restart` is low.
- R2: The encoding of `mode` is 2'b00 streaming, 2'b01 transitional and 2'b10 locked. The value 2'b11 never appears.
- R3: In streaming, a sampled falling edge of `scl` while `sda` is high sets `mode` to transitional on the clock edge that detects it. A falling edge of `scl` while `sda` is low has no effect.
- R4: In transitional, each sampled rising edge of `vclk` advances the watchdog. On the 128th edge, `mode` returns to streaming and `restart` is high for exactly that one cycle.
- R5: In transitional, a sampled falling edge of `scl` clears the watchdog, so 128 further `vclk` edges are needed to time out. If the falling edge coincides with a `vclk` rising edge, the clear wins.
- R6: In transitional, `ack_given` with `addr_hi` equal to 4'b1010 sets `mode` to locked. The block then stays locked until reset, whatever `vclk`, `scl`, `sda`, `stop_seen`, `addr_phase` and `ack_given` do, and never pulses `restart`.
- R7: `ack_given` with any other `addr_hi` value does not lock, and the 128-edge timeout still returns the block to streaming.
- R8: In transitional, `stop_seen` while `addr_phase` is high returns the block to streaming with a one-cycle `restart` pulse. `stop_seen` while `addr_phase` is low is ignored.
- R9: If a locking acknowledge coincides with the 128th `vclk` edge, locking wins and no `restart` pulse is produced.
- R10: In streaming, `vclk` edges, `stop_seen` and `ack_given` change neither `mode` nor `restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| scl | input | 1 | Two-wire bus clock level |
| sda | input | 1 | Two-wire bus data level (high means released) |
| vclk | input | 1 | Slow streaming clock level |
| stop_seen | input | 1 | One-cycle stop-condition strobe from the slave engine |
| addr_phase | input | 1 | High while the slave engine is receiving the address byte |
| ack_given | input | 1 | One-cycle strobe when the slave engine acknowledges an address |
| addr_hi | input | 4 | Upper four bits of the received address, valid with `ack_given` |
| mode | output | 2 | Registered mode: 00 streaming, 01 transitional, 10 locked |
| restart | output | 1 | One-cycle pulse telling the streamer to restart at address zero |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the watchdog's terminal `vclk` edge and the locking acknowledge. The second pair is a `vclk` rising edge and an `scl` falling edge that clears the watchdog. The bench first brings the count to 127, then raises `vclk` in the same sampled cycle as the competing strobe. It judges the result by the mode and the restart pulse one cycle later: the block must be locked with no pulse in the first case, and still transitional in the second. After the clear, an exact sweep of 127 more edges must not revert the block, and the 128th must.

// File: rtl/bus_mode_ctrl.sv
module bus_mode_ctrl #(
  parameter int WDOG_LIMIT = 128,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic       vclk,
  input  logic       stop_seen,
  input  logic       addr_phase,
  input  logic       ack_given,
  input  logic [3:0] addr_hi,
  output logic [1:0] mode,
  output logic       restart
);
  localparam int CNT_W = $clog2(WDOG_LIMIT) + 1;
  localparam logic [1:0] ST_STREAM = 2'b00;
  localparam logic [1:0] ST_TRANS  = 2'b01;
  localparam logic [1:0] ST_LOCK   = 2'b10;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(WDOG_LIMIT);

  logic             scl_q, vclk_q;
  logic [CNT_W-1:0] cnt, cnt_inc;
  logic [1:0]       mode_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             restart_nx;

  wire scl_fall  = scl_q & ~scl;
  wire vclk_rise = ~vclk_q & vclk;
  wire lock_hit  = ack_given && (addr_hi == DEV_CODE);
  wire stop_addr = stop_seen && addr_phase;
  assign cnt_inc = cnt + 1'b1;

  always_comb begin
    mode_nx    = mode;
    cnt_nx     = '0;
    restart_nx = 1'b0;
    case (mode)
      ST_STREAM: if (scl_fall && sda) mode_nx = ST_TRANS;
      ST_TRANS: begin
        if (lock_hit) begin
          mode_nx = ST_LOCK;
        end else if (stop_addr) begin
          mode_nx    = ST_STREAM;
          restart_nx = 1'b1;
        end else if (scl_fall) begin
          cnt_nx = '0;
        end else if (vclk_rise) begin
          if (cnt_inc == TERM) begin
            mode_nx    = ST_STREAM;
            restart_nx = 1'b1;
          end else begin
            cnt_nx = cnt_inc;
          end
        end else begin
          cnt_nx = cnt;
        end
      end
      default: mode_nx = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      vclk_q  <= 1'b0;
      mode    <= ST_STREAM;
      cnt     <= '0;
      restart <= 1'b0;
    end else begin
      scl_q   <= scl;
      vclk_q  <= vclk;
      mode    <= mode_nx;
      cnt     <= cnt_nx;
      restart <= restart_nx;
    end
  end
endmodule

// File: rtl/bus_mode_ctrl_chk.sv
module bus_mode_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             restart,
  input logic [CNT_W-1:0] cnt
);
  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> (mode == 2'b00 && !restart));

  // R2
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'b11);

  // R4
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n) restart |=> !restart);

  // R4
  restart_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (mode == 2'b00 && $past(mode) == 2'b01));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (mode == 2'b10 && !restart));

  // R3
  no_direct_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (mode != 2'b10));

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> (cnt == '0));
endmodule

bind bus_mode_ctrl bus_mode_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .restart(restart), .cnt(cnt)
);

// File: tb/bus_mode_ctrl_tb_top.sv
module bus_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, vclk = 1'b0;
  logic stop_seen = 1'b0, addr_phase = 1'b0, ack_given = 1'b0;
  logic [3:0] addr_hi = 4'h0;
  logic [1:0] mode;
  logic restart;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  localparam logic [1:0] S = 2'b00, T = 2'b01, L = 2'b10;

  bus_mode_ctrl dut_i (.clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .vclk(vclk),
    .stop_seen(stop_seen), .addr_phase(addr_phase), .ack_given(ack_given),
    .addr_hi(addr_hi), .mode(mode), .restart(restart));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [1:0] em, input logic er);
    checks++;
    if (mode !== em || restart !== er) begin
      errors++;
      $display("FAIL %s: mode=%b restart=%b expected mode=%b restart=%b", req, mode, restart, em, er);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; vclk = 1'b0;
    stop_seen = 0; addr_phase = 0; ack_given = 0; addr_hi = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic vedge();
    vclk = 1'b0; @(negedge clk);
    vclk = 1'b1; @(negedge clk);
  endtask

  task automatic sfall(input logic d);
    scl = 1'b1; sda = d; @(negedge clk);
    scl = 1'b0; @(negedge clk);
    sda = 1'b1;
  endtask

  task automatic enter_trans();
    sfall(1'b1);
    chk("R3 enter", T, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset", S, 1'b0);

    // R10: streaming ignores vclk and strobes
    for (int i = 0; i < 200; i++) vedge();
    chk("R10 vclk", S, 1'b0);
    stop_seen = 1; addr_phase = 1; ack_given = 1; addr_hi = 4'b1010;
    @(negedge clk);
    stop_seen = 0; addr_phase = 0; ack_given = 0;
    @(negedge clk);
    chk("R10 strobes", S, 1'b0);

    // R3: scl fall with sda low is ignored
    sfall(1'b0);
    chk("R3 sda low", S, 1'b0);

    // R4: exact 128-edge sweep, R2 encodings checked along the way
    enter_trans();
    for (int i = 1; i <= 128; i++) begin
      vedge();
      chk(i < 128 ? "R4 counting" : "R4 timeout", i < 128 ? T : S, i == 128);
    end
    @(negedge clk);
    chk("R4 pulse width", S, 1'b0);

    // R5: clear midway, then 127 more do not revert, 128th does
    for (int k = 1; k <= 127; k += 42) begin
      enter_trans();
      for (int i = 0; i < k; i++) vedge();
      sfall(1'b1);
      chk("R5 after clear", T, 1'b0);
      for (int i = 1; i <= 128; i++) begin
        vedge();
        if (i >= 127) chk("R5 recount", i < 128 ? T : S, i == 128);
      end
    end

    // R5: clear coincides with the 128th edge
    enter_trans();
    for (int i = 0; i < 127; i++) vedge();
    vclk = 1'b0; scl = 1'b1; @(negedge clk);
    vclk = 1'b1; scl = 1'b0; @(negedge clk);
    chk("R5 coincident clear", T, 1'b0);
    for (int i = 1; i <= 128; i++) vedge();
    chk("R5 coincident timeout", S, 1'b1);

    // R7: every wrong device code leaves mode unlocked
    for (int c = 0; c < 16; c++) begin
      if (c == 10) continue;
      enter_trans();
      addr_hi = 4'(c); ack_given = 1; @(negedge clk);
      ack_given = 0; @(negedge clk);
      chk("R7 wrong code", T, 1'b0);
      for (int i = 0; i < 128; i++) vedge();
      chk("R7 timeout", S, 1'b1);
    end

    // R8: stop outside address phase ignored, inside reverts
    enter_trans();
    stop_seen = 1; addr_phase = 0; @(negedge clk);
    stop_seen = 0; @(negedge clk);
    chk("R8 stop ignored", T, 1'b0);
    stop_seen = 1; addr_phase = 1; @(negedge clk);
    chk("R8 stop revert", S, 1'b1);
    stop_seen = 0; addr_phase = 0; @(negedge clk);
    chk("R8 pulse end", S, 1'b0);

    // R6: lock and stay locked
    enter_trans();
    for (int i = 0; i < 50; i++) vedge();
    addr_hi = 4'b1010; ack_given = 1; @(negedge clk);
    ack_given = 0;
    chk("R6 lock", L, 1'b0);
    for (int i = 0; i < 300; i++) vedge();
    chk("R6 vclk", L, 1'b0);
    sfall(1'b1);
    stop_seen = 1; addr_phase = 1; @(negedge clk);
    stop_seen = 0; addr_phase = 0; @(negedge clk);
    chk("R6 stop", L, 1'b0);
    do_reset();
    chk("R1 reset after lock", S, 1'b0);

    // R9: lock coincides with the 128th edge
    enter_trans();
    for (int i = 0; i < 127; i++) vedge();
    vclk = 1'b0; @(negedge clk);
    vclk = 1'b1; addr_hi = 4'b1010; ack_given = 1; @(negedge clk);
    ack_given = 0;
    chk("R9 lock wins", L, 1'b0);
    @(negedge clk);
    chk("R9 no pulse", L, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule